// File: doc/BRIEF.md
# Frame-counted HDLC transmit FIFO

This block buffers complete HDLC frames on their way from a host to a serial line. The host pushes payload bytes one at a time. It then issues an end-of-frame command, which closes the current frame. Frame boundaries are not marked in the byte stream. Instead, a small circular table holds the address of the last byte of each closed frame. The table is indexed by an input frame counter that wraps. The start of any frame is the slot after the end recorded for the frame before it, so the table keeps no start addresses.

The line side only sees closed frames. It consumes bytes strictly in order, and the output frame counter steps when the byte at the recorded end address is taken. Line output is gated by a select pulse. The pulse starts transmission whether or not the FIFO is already selected. Sending stops on its own after the last closed frame has gone out, and a new pulse is then needed. Two independent limits make the FIFO full. The first is a frame-count limit that always keeps one counter value unused. The second is a byte-space limit on the payload memory. Flag, CRC and bit stuffing are handled downstream.

Top module: `hdlc_txfifo`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `frame_count` is 0, and `overflow`, `full`, `frame_cnt_full`, `byte_full` and `rd_valid` are all 0.
- R2: Writing bytes with `eof_cmd` low never changes `frame_count`. After the first accepted byte, `empty` is 0.
- R3: An `eof_cmd` for a frame that holds at least one byte raises `frame_count` by one on the next cycle. Once sending, the frame's bytes appear on `rd_data` in write order, and `rd_last` is 1 only on the last byte.
- R4: Each frame begins at the byte slot directly after the previous frame's last byte, so back-to-back frames read out contiguously with correct `rd_last` boundaries.
- R5: When `wr_en` and `eof_cmd` are high in the same cycle, the byte written in that cycle is the last byte of the frame being closed.
- R6: An `eof_cmd` while no byte is held in the open frame is ignored. It leaves `frame_count` and `overflow` unchanged.
- R7: With a frame counter of FW bits, `frame_cnt_full` (and `full`) is 1 exactly when 2^FW−1 frames are stored. This holds even when byte space remains. An `eof_cmd` in that state is dropped and sets the sticky `overflow`.
- R8: With 2^AW payload bytes stored, `byte_full` and `full` are 1. A write in that state is discarded and sets `overflow`.
- R9: `rd_valid` stays 0 until `sel` is pulsed, even when closed frames are stored.
- R10: A `sel` pulse starts sending, including while already sending. Sending stops after a frame's last byte is taken if that frame was the only closed frame at that moment. In that case `rd_valid` is 0 until the next `sel`.
- R11: `frame_count` equals the input frame counter minus the output frame counter, modulo 2^FW. It falls by one when a byte with `rd_last` is taken. It is unchanged if a frame is also closed in that same cycle.
- R12: A synchronous reset in mid-operation discards all stored frames and bytes and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DW | Host payload byte |
| eof_cmd | input | 1 | Close the current frame |
| sel | input | 1 | Select or reselect pulse; starts line output |
| rd_en | input | 1 | Line side takes the byte on `rd_data` |
| rd_data | output | DW | Byte at the output pointer |
| rd_valid | output | 1 | Sending and a closed frame is stored |
| rd_last | output | 1 | Current byte ends its frame |
| frame_count | output | FW | Number of closed frames stored |
| frame_cnt_full | output | 1 | Frame-count limit reached |
| byte_full | output | 1 | Payload memory full |
| full | output | 1 | Either full condition |
| empty | output | 1 | No closed frame and no open frame |
| overflow | output | 1 | Sticky: a write or end-of-frame was dropped |

## Verification
Two pairs of operations can collide in one cycle, and both are provoked on purpose. The first pair is a byte write and the end-of-frame command. They are raised together, and the readout must then show that byte flagged as last. The second pair is the line side taking a frame's last byte while the host closes another frame. Here the bench expects `frame_count` to stay put, and sending to stop anyway because only one closed frame existed when the take happened. A fresh select must then release the new frame.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;

    localparam int TXF_DATA_W = 8;
    localparam int TXF_ADDR_W = 6;
    localparam int TXF_FCNT_W = 5;

    typedef enum logic {
        LINE_IDLE = 1'b0,
        LINE_SEND = 1'b1
    } line_state_e;

    // Events that may set the sticky overflow flag, plus the limit flags.
    typedef struct packed {
        logic frame_full;
        logic byte_full;
        logic eof_drop;
        logic wr_drop;
    } txf_evt_t;

endpackage

// File: rtl/txf_byte_store.sv
module txf_byte_store
    import hdlc_txf_pkg::*;
#(
    parameter int AW = TXF_ADDR_W,
    parameter int DW = TXF_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          wr_accept
);
    localparam int DEPTH = 1 << AW;

    logic [AW:0]   wr_ptr;
    logic [AW:0]   rd_ptr;
    logic [AW:0]   used;
    logic [DW-1:0] mem [DEPTH];

    // used never exceeds DEPTH, so its top bit marks exactly DEPTH bytes
    assign used      = wr_ptr - rd_ptr;
    assign full      = used[AW];
    assign wr_accept = wr_req && !full;
    assign wr_addr   = wr_ptr[AW-1:0];
    assign rd_addr   = rd_ptr[AW-1:0];
    assign rd_data   = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_accept) wr_ptr <= wr_ptr + 1'b1;
            if (rd_req)    rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_accept) mem[wr_addr] <= wr_data;
    end

endmodule

// File: rtl/txf_frame_table.sv
module txf_frame_table
    import hdlc_txf_pkg::*;
#(
    parameter int AW = TXF_ADDR_W,
    parameter int FW = TXF_FCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eof_req,
    input  logic          wr_accept,
    input  logic [AW-1:0] wr_addr,
    input  logic          out_done,
    output logic [AW-1:0] head_end,
    output logic [FW-1:0] frames,
    output logic          frame_full,
    output logic          open,
    output logic          eof_drop
);
    localparam int SLOTS = 1 << FW;

    logic [FW-1:0] f_in;
    logic [FW-1:0] f_out;
    logic [AW-1:0] end_tab [SLOTS];
    logic          open_q;
    logic          has_data;
    logic          eof_ok;
    logic [AW-1:0] new_end;

    assign frames     = f_in - f_out;
    assign frame_full = &frames;
    assign has_data   = open_q || wr_accept;
    assign eof_ok     = eof_req && has_data && !frame_full;
    assign eof_drop   = eof_req && has_data && frame_full;
    // a byte written in the closing cycle is the frame's last byte
    assign new_end    = wr_accept ? wr_addr : wr_addr - 1'b1;
    assign head_end   = end_tab[f_out];
    assign open       = open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_in   <= '0;
            f_out  <= '0;
            open_q <= 1'b0;
            for (int i = 0; i < SLOTS; i++) end_tab[i] <= '0;
        end else begin
            if (eof_ok) begin
                end_tab[f_in] <= new_end;
                f_in          <= f_in + 1'b1;
            end
            if (out_done) f_out <= f_out + 1'b1;
            open_q <= has_data && !eof_ok;
        end
    end

endmodule

// File: rtl/txf_line_ctrl.sv
module txf_line_ctrl
    import hdlc_txf_pkg::*;
#(
    parameter int FW = TXF_FCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          rd_en,
    input  logic [FW-1:0] frames,
    input  logic          at_end,
    output logic          rd_valid,
    output logic          rd_last,
    output logic          take,
    output logic          done
);
    line_state_e st;

    assign rd_valid = (st == LINE_SEND) && (frames != '0);
    assign rd_last  = rd_valid && at_end;
    assign take     = rd_en && rd_valid;
    assign done     = take && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= LINE_IDLE;
        end else if (sel) begin
            st <= LINE_SEND;
        end else if (done && frames == FW'(1)) begin
            st <= LINE_IDLE;
        end
    end

endmodule

// File: rtl/hdlc_txfifo.sv
module hdlc_txfifo
    import hdlc_txf_pkg::*;
#(
    parameter int DW = TXF_DATA_W,
    parameter int AW = TXF_ADDR_W,
    parameter int FW = TXF_FCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          eof_cmd,
    input  logic          sel,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rd_last,
    output logic [FW-1:0] frame_count,
    output logic          frame_cnt_full,
    output logic          byte_full,
    output logic          full,
    output logic          empty,
    output logic          overflow
);
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] head_end;
    logic          wr_accept;
    logic          take;
    logic          done;
    logic          open;
    logic          eof_drop;
    logic          bfull;
    logic          ffull;
    logic [FW-1:0] frames;
    txf_evt_t      evt;
    logic          ovf_q;

    txf_byte_store #(.AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_en),
        .wr_data   (wr_data),
        .rd_req    (take),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .full      (bfull),
        .wr_accept (wr_accept)
    );

    txf_frame_table #(.AW(AW), .FW(FW)) u_table (
        .clk        (clk),
        .rst        (rst),
        .eof_req    (eof_cmd),
        .wr_accept  (wr_accept),
        .wr_addr    (wr_addr),
        .out_done   (done),
        .head_end   (head_end),
        .frames     (frames),
        .frame_full (ffull),
        .open       (open),
        .eof_drop   (eof_drop)
    );

    txf_line_ctrl #(.FW(FW)) u_line (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .rd_en    (rd_en),
        .frames   (frames),
        .at_end   (rd_addr == head_end),
        .rd_valid (rd_valid),
        .rd_last  (rd_last),
        .take     (take),
        .done     (done)
    );

    always_comb begin
        evt.frame_full = ffull;
        evt.byte_full  = bfull;
        evt.eof_drop   = eof_drop;
        evt.wr_drop    = wr_en && bfull;
    end

    always_ff @(posedge clk) begin
        if (rst)                            ovf_q <= 1'b0;
        else if (evt.eof_drop || evt.wr_drop) ovf_q <= 1'b1;
    end

    assign frame_count    = frames;
    assign frame_cnt_full = evt.frame_full;
    assign byte_full      = evt.byte_full;
    assign full           = evt.frame_full || evt.byte_full;
    assign empty          = (frames == '0) && !open;
    assign overflow       = ovf_q;

endmodule

// File: rtl/hdlc_txfifo_chk.sv
module hdlc_txfifo_chk #(
    parameter int FW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          eof_cmd,
    input logic          rd_en,
    input logic          rd_valid,
    input logic          rd_last,
    input logic [FW-1:0] frame_count,
    input logic          frame_cnt_full,
    input logic          empty,
    input logic          overflow
);
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (frame_count == '0 && empty && !overflow && !rd_valid));

    a_r2_count_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(eof_cmd) && !$past(rd_en && rd_last))
            |-> frame_count == $past(frame_count));

    a_r3_last_is_valid: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(frame_cnt_full))
            |-> frame_count != FW'($past(frame_count) + 1'b1));

    a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(overflow)) |-> overflow);

    a_r9_valid_needs_frame: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> frame_count != '0);

    a_r11_read_decrements: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_en && rd_last) && !$past(eof_cmd))
            |-> frame_count == FW'($past(frame_count) - 1'b1));

endmodule

bind hdlc_txfifo hdlc_txfifo_chk #(.FW(FW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .eof_cmd        (eof_cmd),
    .rd_en          (rd_en),
    .rd_valid       (rd_valid),
    .rd_last        (rd_last),
    .frame_count    (frame_count),
    .frame_cnt_full (frame_cnt_full),
    .empty          (empty),
    .overflow       (overflow)
);

// File: tb/hdlc_txfifo_bench.sv
module hdlc_txfifo_bench;
    localparam int PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 6;
    localparam int FW = 5;
    localparam int NVEC = 8;
    // {byte, close-frame-in-same-cycle}
    localparam logic [8:0] VEC [NVEC] = '{
        {8'hA1, 1'b0}, {8'hB2, 1'b0}, {8'hC3, 1'b1},
        {8'hD4, 1'b1},
        {8'hE5, 1'b0}, {8'hF6, 1'b0}, {8'h07, 1'b0}, {8'h18, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic eof_cmd = 1'b0;
    logic sel = 1'b0;
    logic rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic rd_valid, rd_last, frame_cnt_full, byte_full, full, empty, overflow;
    logic [FW-1:0] frame_count;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    hdlc_txfifo #(.DW(DW), .AW(AW), .FW(FW)) u_hdlc_txfifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .eof_cmd(eof_cmd), .sel(sel), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
        .frame_count(frame_count), .frame_cnt_full(frame_cnt_full),
        .byte_full(byte_full), .full(full), .empty(empty), .overflow(overflow)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); rst = 1'b0;
    endtask

    task automatic put(input logic [7:0] d, input logic close);
        wr_en = 1'b1; wr_data = d; eof_cmd = close;
        tick();
        wr_en = 1'b0; eof_cmd = 1'b0;
    endtask

    task automatic pulse_sel();
        sel = 1'b1; tick(); sel = 1'b0;
    endtask

    task automatic take(input string req, input int exp_d, input int exp_last);
        eq({req, " valid"}, int'(rd_valid), 1);
        eq({req, " data"}, int'(rd_data), exp_d);
        eq({req, " last"}, int'(rd_last), exp_last);
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        eq("R1 empty", int'(empty), 1);
        eq("R1 count", int'(frame_count), 0);
        eq("R1 full", int'(full), 0);
        eq("R1 overflow", int'(overflow), 0);
        eq("R1 valid", int'(rd_valid), 0);

        // vector walk: writes with same-cycle closes (R5), three frames
        for (int i = 0; i < NVEC; i++) begin
            put(VEC[i][8:1], VEC[i][0]);
            if (i == 1) begin
                eq("R2 count held", int'(frame_count), 0);
                eq("R2 not empty", int'(empty), 0);
            end
        end
        eq("R3 count three", int'(frame_count), 3);
        tick();
        eq("R9 idle until select", int'(rd_valid), 0);
        pulse_sel();
        for (int i = 0; i < NVEC; i++) begin
            take("R4/R5 readout", int'(VEC[i][8:1]), int'(VEC[i][0]));
            if (i == 0) pulse_sel(); // R10 reselect while sending
        end
        eq("R11 count back to zero", int'(frame_count), 0);
        eq("R3 empty after drain", int'(empty), 1);

        // R6 close with nothing open
        eof_cmd = 1'b1; tick(); eof_cmd = 1'b0;
        eq("R6 count", int'(frame_count), 0);
        eq("R6 overflow", int'(overflow), 0);

        // collision of final take with a new close (R10, R11)
        put(8'h31, 1'b0);
        eq("R2 count after write", int'(frame_count), 0);
        put(8'h32, 1'b1);
        eq("R3 count one", int'(frame_count), 1);
        eq("R10 stopped after drain", int'(rd_valid), 0);
        pulse_sel();
        take("R3 first", 8'h31, 0);
        eq("R3 last valid", int'(rd_valid), 1);
        eq("R3 last data", int'(rd_data), 8'h32);
        eq("R3 last flag", int'(rd_last), 1);
        rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h33; eof_cmd = 1'b1;
        tick();
        rd_en = 1'b0; wr_en = 1'b0; eof_cmd = 1'b0;
        eq("R11 count unchanged", int'(frame_count), 1);
        eq("R10 stop despite new frame", int'(rd_valid), 0);
        pulse_sel();
        take("R10 restart", 8'h33, 1);
        eq("R11 count zero", int'(frame_count), 0);

        // R7 frame-count limit
        do_reset();
        for (int i = 0; i < 31; i++) put(8'(i), 1'b1);
        eq("R7 count 31", int'(frame_count), 31);
        eq("R7 frame full", int'(frame_cnt_full), 1);
        eq("R7 full", int'(full), 1);
        eq("R7 bytes left", int'(byte_full), 0);
        eq("R7 no overflow yet", int'(overflow), 0);
        put(8'h77, 1'b1);
        eq("R7 close dropped", int'(frame_count), 31);
        eq("R7 overflow set", int'(overflow), 1);
        pulse_sel();
        take("R7 first frame", 0, 1);
        eq("R7 count 30", int'(frame_count), 30);
        eq("R7 frame full clear", int'(frame_cnt_full), 0);
        eq("R7 overflow sticky", int'(overflow), 1);

        // R12 reset in mid-operation
        do_reset();
        eq("R12 count", int'(frame_count), 0);
        eq("R12 empty", int'(empty), 1);
        eq("R12 overflow", int'(overflow), 0);
        eq("R12 valid", int'(rd_valid), 0);

        // R8 byte-space limit
        for (int i = 0; i < 64; i++) put(8'(i + 100), 1'b0);
        eq("R8 byte full", int'(byte_full), 1);
        eq("R8 full", int'(full), 1);
        eq("R8 count", int'(frame_count), 0);
        put(8'hEE, 1'b0);
        eq("R8 overflow", int'(overflow), 1);
        eof_cmd = 1'b1; tick(); eof_cmd = 1'b0;
        eq("R8 closed", int'(frame_count), 1);
        pulse_sel();
        for (int i = 0; i < 64; i++) take("R8 readout", i + 100, (i == 63) ? 1 : 0);
        eq("R8 drained", int'(frame_count), 0);
        eq("R8 byte full clear", int'(byte_full), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule